// File: doc/BRIEF.md
# OTP Protection Register Controller

This block holds a small one-time-programmable register file behind a flash-style command interface. The file has nine 16-bit words: a lock word, a 64-bit factory segment that carries a unique device number, and a 64-bit segment that the user can program. A write is a two-step command. The first bus write carries the program opcode. The second carries the target word address and the 16-bit value. Programming can only clear bits, so a stored word can never be restored to ones.

The lock word gates both segments. Its bit 0 is already cleared when the part powers up, so the factory segment is read-only. Clearing bit 1 freezes the user segment, and nothing can undo that, including a reset. A status byte reports readiness and two sticky error flags, and it is visible at all times on its own output. An address violation and a lock violation set different combinations of the error flags. Reads return stored words one cycle after they are requested.

A power-on input loads the fresh fuse contents, which stands in for the state the non-volatile cells hold at power-up. The ordinary reset only returns the command sequencer and the status flags to idle.

Top module: `otp_guard_ctrl`

## Requirements
- R1: After power-on, word 0x80 reads 0xFFFE and words 0x81..0x84 read the factory ID in 16-bit slices, lowest slice at 0x81. Words 0x85..0x88 read 0xFFFF, and any address outside 0x80..0x88 reads 0xFFFF. A read request is answered on the next cycle with `rd_valid` high.
- R2: A program takes two bus writes. The first has low data byte 0xC0 and its address is ignored. The second gives the address and the data. A first write with any other low byte, apart from 0x50, starts nothing.
- R3: A program that succeeds stores the bitwise AND of the old word and the new data.
- R4: `status[7]` (ready) is low for exactly PROG_CYCLES cycles after the second write is accepted. The data and error updates are visible when ready returns high.
- R5: Bus writes accepted while ready is low have no effect. They neither program a word nor arm a new command.
- R6: A program to an address outside 0x80..0x88 sets `status[4]` only and changes no word.
- R7: A program to a word in a locked segment sets both `status[4]` and `status[1]` and leaves the word unchanged. The factory segment (0x81..0x84) is locked from power-on.
- R8: Programming 0xFFFD to 0x80 locks the user segment (0x85..0x88). Later programs of 0x80 and later resets never unlock it.
- R9: `status[4]` and `status[1]` stay set until a write with low data byte 0x50 arrives while idle, which clears both. All other status bits read 0.
- R10: `rst_n` disarms a pending command and clears the error flags. It does not change the stored words or the lock bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous active-low power-on load of the fuse contents |
| rst_n | input | 1 | Synchronous active-low controller reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | DATA_W | Read data |
| status | output | 8 | Bit 7 ready, bit 4 program error, bit 1 lock error, others 0 |

## Verification
Nearly every internal fault shows up within one command. A wrong lock or range decision gives a wrong status byte as soon as ready returns. A wrong store update gives a wrong word on the next read of that address. A sequencer that stays armed or counts wrongly shows up as a wrong ready-low length, or as a later harmless-looking write that changes a word. The random phase checks each program against a bench model of the nine words and the two flags, and it reads the target word back straight away, so a corrupted word is caught within a few cycles.

// File: rtl/otp_guard_pkg.sv
`timescale 1ns/1ps
// Shared types and command codes for the OTP protection register controller.
// Assumes 8-bit command opcodes carried in the low data byte.
package otp_guard_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_BUSY  = 2'd2
    } seq_state_t;

    localparam logic [7:0] OP_PROT_PROG = 8'hC0;
    localparam logic [7:0] OP_CLR_STAT  = 8'h50;

    typedef struct packed {
        logic addr_bad;
        logic lock_bad;
    } verdict_t;

endpackage

// File: rtl/otp_cmd_seq.sv
`timescale 1ns/1ps
// Command sequencer: decodes the two-write program command and the
// clear-status command, latches the target, and times the busy window.
// Assumes writes arriving while busy are to be dropped silently.
module otp_cmd_seq
    import otp_guard_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              busy,
    output logic              commit,
    output logic              clr_err,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wr_req;

    assign wr_req  = bus_valid && bus_write;
    assign busy    = (state_q == SEQ_BUSY);
    assign commit  = busy && (cnt_q == CNT_ONE);
    assign clr_err = (state_q == SEQ_IDLE) && wr_req && (bus_wdata[7:0] == OP_CLR_STAT);

    // Advance the command state and the busy countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            cnt_q    <= '0;
            tgt_addr <= '0;
            tgt_data <= '1;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (wr_req && bus_wdata[7:0] == OP_PROT_PROG) begin
                        state_q <= SEQ_ARMED;
                    end
                end
                SEQ_ARMED: begin
                    if (wr_req) begin
                        tgt_addr <= bus_addr;
                        tgt_data <= bus_wdata;
                        cnt_q    <= CNT_LOAD;
                        state_q  <= SEQ_BUSY;
                    end
                end
                SEQ_BUSY: begin
                    cnt_q <= cnt_q - CNT_ONE;
                    if (cnt_q == CNT_ONE) begin
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/otp_access_check.sv
`timescale 1ns/1ps
// Access checker: classifies a program target as out of range, locked,
// or allowed, and gives the word index inside the register window.
// Assumes the lock word's bit 0 guards the factory segment, bit 1 the user one.
module otp_access_check
    import otp_guard_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                SEG_WORDS = 4,
    parameter logic [ADDR_W-1:0] PR_BASE   = 8'h80
) (
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [1:0]                         lock_bits,
    output verdict_t                           verdict,
    output logic [$clog2(2*SEG_WORDS+1)-1:0]   idx
);
    localparam int IDX_W  = $clog2(2 * SEG_WORDS + 1);
    localparam int NWORDS = 2 * SEG_WORDS + 1;
    localparam logic [ADDR_W-1:0] LAST_A = PR_BASE + ADDR_W'(NWORDS - 1);
    localparam logic [IDX_W-1:0]  FAC_LO = IDX_W'(1);
    localparam logic [IDX_W-1:0]  FAC_HI = IDX_W'(SEG_WORDS);

    logic in_win, in_fac, in_usr;

    // Decode window membership and segment, then apply the lock bits.
    always_comb begin
        in_win = (addr >= PR_BASE) && (addr <= LAST_A);
        idx    = IDX_W'(addr - PR_BASE);
        in_fac = in_win && (idx >= FAC_LO) && (idx <= FAC_HI);
        in_usr = in_win && (idx > FAC_HI);
        verdict.addr_bad = !in_win;
        verdict.lock_bad = (in_fac && !lock_bits[0]) || (in_usr && !lock_bits[1]);
    end

endmodule

// File: rtl/otp_word_bank.sv
`timescale 1ns/1ps
// Word bank: the nine OTP words. Each write ANDs into one word, so bits only
// ever clear. Only the power-on input restores the fuse image.
// Assumes por_n is asserted once before use.
module otp_word_bank #(
    parameter int                          DATA_W     = 16,
    parameter int                          SEG_WORDS  = 4,
    parameter logic [SEG_WORDS*DATA_W-1:0] FACTORY_ID = 64'h3A5C_91E7_0D42_B86F
) (
    input  logic                                  clk,
    input  logic                                  por_n,
    input  logic                                  wr_en,
    input  logic [$clog2(2*SEG_WORDS+1)-1:0]      wr_idx,
    input  logic [DATA_W-1:0]                     wr_data,
    input  logic [$clog2(2*SEG_WORDS+1)-1:0]      rd_idx,
    output logic [DATA_W-1:0]                     rd_word,
    output logic [DATA_W-1:0]                     lock_word,
    output logic [(2*SEG_WORDS+1)*DATA_W-1:0]     bank_flat
);
    localparam int IDX_W  = $clog2(2 * SEG_WORDS + 1);
    localparam int NWORDS = 2 * SEG_WORDS + 1;

    logic [DATA_W-1:0] words [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        logic [DATA_W-1:0] init_v;
        if (g == 0) begin : g_lock
            assign init_v = ~DATA_W'(1);
        end else if (g <= SEG_WORDS) begin : g_fac
            assign init_v = FACTORY_ID[(g-1)*DATA_W +: DATA_W];
        end else begin : g_usr
            assign init_v = '1;
        end

        // Load the fuse image at power-on, else clear bits on a write.
        always_ff @(posedge clk) begin
            if (!por_n) begin
                words[g] <= init_v;
            end else if (wr_en && wr_idx == MY_IDX) begin
                words[g] <= words[g] & wr_data;
            end
        end

        assign bank_flat[g*DATA_W +: DATA_W] = words[g];
    end

    assign lock_word = words[0];

    // Select the read word; out-of-window indices read all ones.
    always_comb begin
        rd_word = '1;
        for (int i = 0; i < NWORDS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_word = words[i];
        end
    end

endmodule

// File: rtl/otp_status_reg.sv
`timescale 1ns/1ps
// Status flags: sticky program and lock errors, set when a command completes,
// cleared by the clear-status command or by reset.
module otp_status_reg
    import otp_guard_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     commit,
    input  verdict_t verdict,
    input  logic     clr_err,
    output logic     err_prog,
    output logic     err_lock
);
    // Accumulate error flags until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_err) begin
            err_prog <= 1'b0;
            err_lock <= 1'b0;
        end else if (commit) begin
            err_prog <= err_prog | verdict.addr_bad | verdict.lock_bad;
            err_lock <= err_lock | verdict.lock_bad;
        end
    end

endmodule

// File: rtl/otp_guard_ctrl.sv
`timescale 1ns/1ps
// OTP protection register controller top: connects the sequencer, the access
// checker, the word bank and the status flags, and registers the read port.
// Assumes one bus request per cycle and no back-pressure.
module otp_guard_ctrl
    import otp_guard_pkg::*;
#(
    parameter int                          ADDR_W      = 8,
    parameter int                          DATA_W      = 16,
    parameter int                          SEG_WORDS   = 4,
    parameter int                          PROG_CYCLES = 6,
    parameter logic [ADDR_W-1:0]           PR_BASE     = 8'h80,
    parameter logic [SEG_WORDS*DATA_W-1:0] FACTORY_ID  = 64'h3A5C_91E7_0D42_B86F
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [7:0]        status
);
    localparam int IDX_W  = $clog2(2 * SEG_WORDS + 1);
    localparam int NWORDS = 2 * SEG_WORDS + 1;
    localparam logic [ADDR_W-1:0] LAST_A = PR_BASE + ADDR_W'(NWORDS - 1);

    logic                     busy, commit, clr_err;
    logic [ADDR_W-1:0]        tgt_addr;
    logic [DATA_W-1:0]        tgt_data;
    verdict_t                 verdict;
    logic [IDX_W-1:0]         wr_idx, rd_idx;
    logic [DATA_W-1:0]        rd_word, lock_word;
    logic [NWORDS*DATA_W-1:0] bank_flat;
    logic                     err_prog, err_lock;
    logic                     rd_hit;

    otp_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) seq_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy), .commit(commit),
        .clr_err(clr_err), .tgt_addr(tgt_addr), .tgt_data(tgt_data)
    );

    otp_access_check #(.ADDR_W(ADDR_W), .SEG_WORDS(SEG_WORDS), .PR_BASE(PR_BASE)) chk_acc_i (
        .addr(tgt_addr), .lock_bits(lock_word[1:0]), .verdict(verdict), .idx(wr_idx)
    );

    otp_word_bank #(.DATA_W(DATA_W), .SEG_WORDS(SEG_WORDS), .FACTORY_ID(FACTORY_ID)) bank_i (
        .clk(clk), .por_n(por_n),
        .wr_en(commit && !verdict.addr_bad && !verdict.lock_bad),
        .wr_idx(wr_idx), .wr_data(tgt_data), .rd_idx(rd_idx), .rd_word(rd_word),
        .lock_word(lock_word), .bank_flat(bank_flat)
    );

    otp_status_reg stat_i (
        .clk(clk), .rst_n(rst_n), .commit(commit), .verdict(verdict),
        .clr_err(clr_err), .err_prog(err_prog), .err_lock(err_lock)
    );

    assign rd_hit = (bus_addr >= PR_BASE) && (bus_addr <= LAST_A);
    assign rd_idx = IDX_W'(bus_addr - PR_BASE);
    assign status = {~busy, 2'b00, err_prog, 2'b00, err_lock, 1'b0};

    // Register the read response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '1;
        end else begin
            rd_valid <= bus_valid && !bus_write;
            if (bus_valid && !bus_write) rd_data <= rd_hit ? rd_word : '1;
        end
    end

endmodule

// File: rtl/otp_guard_checker.sv
`timescale 1ns/1ps
// Property checker for otp_guard_ctrl, attached through bind.
module otp_guard_checker #(
    parameter int DATA_W      = 16,
    parameter int NWORDS      = 9,
    parameter int PROG_CYCLES = 6
) (
    input logic                     clk,
    input logic                     por_n,
    input logic                     rst_n,
    input logic                     bus_valid,
    input logic                     bus_write,
    input logic                     rd_valid,
    input logic [7:0]               status,
    input logic [DATA_W-1:0]        lock_word,
    input logic [NWORDS*DATA_W-1:0] bank_flat,
    input logic                     clr_err
);
    localparam logic [15:0] LIM = 16'(PROG_CYCLES);
    logic [15:0] low_run;

    // Count consecutive cycles with ready low.
    always_ff @(posedge clk) begin
        if (!rst_n) low_run <= '0;
        else        low_run <= status[7] ? 16'd0 : low_run + 16'd1;
    end

    a_r4_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !status[7] |-> low_run < LIM);

    a_r1_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rd_valid);

    a_r1_no_spurious_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !rd_valid);

    a_r8_user_lock_sticks: assert property (@(posedge clk) disable iff (!por_n)
        !lock_word[1] |=> !lock_word[1]);

    a_r7_factory_lock_sticks: assert property (@(posedge clk) disable iff (!por_n)
        !lock_word[0] |=> !lock_word[0]);

    a_r3_bits_only_clear: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> (bank_flat & ~$past(bank_flat)) == '0);

    a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && !clr_err) |=> status[4]);

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status & 8'h6D) == 8'h00);

endmodule

bind otp_guard_ctrl otp_guard_checker #(
    .DATA_W(DATA_W), .NWORDS(2*SEG_WORDS+1), .PROG_CYCLES(PROG_CYCLES)
) prop_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_valid(bus_valid),
    .bus_write(bus_write), .rd_valid(rd_valid), .status(status),
    .lock_word(lock_word), .bank_flat(bank_flat), .clr_err(clr_err)
);

// File: tb/otp_guard_ctrl_tb_top.sv
`timescale 1ns/1ps
module otp_guard_ctrl_tb_top;
    localparam int          P   = 6;
    localparam logic [63:0] FID = 64'h3A5C_91E7_0D42_B86F;

    logic        clk = 1'b0;
    logic        por_n, rst_n, bus_valid, bus_write;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [7:0]  status;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] exp_w [9];
    logic        exp_ep, exp_el;

    always #10 clk = ~clk;

    otp_guard_ctrl #(.PROG_CYCLES(P), .FACTORY_ID(FID)) dut_i (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .status(status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {1'b1, 2'b00, exp_ep, 2'b00, exp_el, 1'b0};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a);
        logic [15:0] e;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        e = (a >= 8'h80 && a <= 8'h88) ? exp_w[a - 8'h80] : 16'hFFFF;
        chk({tag, " R1 rd_valid"}, {31'd0, rd_valid}, 32'd1);
        chk(tag, {16'd0, rd_data}, {16'd0, e});
    endtask

    task automatic model_apply(input logic [7:0] a, input logic [15:0] d);
        int i;
        if (a < 8'h80 || a > 8'h88) begin
            exp_ep = 1'b1;
        end else begin
            i = a - 8'h80;
            if ((i >= 1 && i <= 4 && !exp_w[0][0]) || (i >= 5 && !exp_w[0][1])) begin
                exp_ep = 1'b1; exp_el = 1'b1;
            end else begin
                exp_w[i] = exp_w[i] & d;
            end
        end
    endtask

    task automatic prog(input string tag, input logic [7:0] a, input logic [15:0] d, input bit inject);
        int cnt;
        wr(8'h00, 16'h00C0);
        wr(a, d);
        cnt = 1;
        if (inject) begin
            wr(8'h80, 16'h00C0);
            wr(8'h86, 16'h0000);
            cnt = 5;
        end
        while (status[7] == 1'b0 && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        if (!inject) chk({tag, " R4 busy length"}, cnt - 1, P);
        model_apply(a, d);
        chk({tag, " status"}, {24'd0, status}, {24'd0, exp_status()});
    endtask

    task automatic do_reset(input bit por);
        @(negedge clk);
        rst_n = 1'b0;
        if (por) por_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        exp_ep = 1'b0; exp_el = 1'b0;
        if (por) begin
            exp_w[0] = 16'hFFFE;
            for (int i = 1; i <= 4; i++) exp_w[i] = FID[(i-1)*16 +: 16];
            for (int i = 5; i <= 8; i++) exp_w[i] = 16'hFFFF;
        end
    endtask

    task automatic read_all(input string tag);
        for (int a = 8'h80; a <= 8'h88; a++) rd_chk(tag, 8'(a));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0]  a;
        logic [15:0] d;
        por_n = 1'b0; rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        void'($urandom(32'd2718));
        do_reset(1'b1);

        // R1: power-on image, idle status, out-of-window reads
        chk("R1 reset status", {24'd0, status}, 32'h80);
        read_all("R1 power-on word");
        rd_chk("R1 below window", 8'h7F);
        rd_chk("R1 above window", 8'h89);

        // R2: a non-program first write must not arm
        wr(8'h80, 16'h00FF);
        wr(8'h85, 16'h0000);
        chk("R2 no arm status", {24'd0, status}, 32'h80);
        rd_chk("R2 unarmed word", 8'h85);

        // R3: AND accumulation
        prog("R3 first", 8'h85, 16'hF0F0, 1'b0);
        prog("R3 second", 8'h85, 16'h3CFF, 1'b0);
        chk("R3 and result", {16'd0, exp_w[5]}, 32'h30F0);
        rd_chk("R3 readback", 8'h85);

        // R5: writes while busy are dropped and do not arm
        prog("R5 busy", 8'h87, 16'hFF00, 1'b1);
        rd_chk("R5 word untouched", 8'h86);
        wr(8'h86, 16'h0000);
        chk("R5 not armed status", {24'd0, status}, 32'h80);
        rd_chk("R5 still untouched", 8'h86);

        // R6 / R9: range error, stickiness, clear
        prog("R6 out of range", 8'h89, 16'h0000, 1'b0);
        chk("R6 status", {24'd0, status}, 32'h90);
        prog("R9 sticky", 8'h88, 16'hFFF0, 1'b0);
        chk("R9 still set", {24'd0, status}, 32'h90);
        wr(8'h00, 16'h0050); exp_ep = 1'b0; exp_el = 1'b0;
        chk("R9 cleared", {24'd0, status}, 32'h80);

        // R7: factory segment locked from power-on
        prog("R7 factory", 8'h81, 16'h0000, 1'b0);
        chk("R7 status", {24'd0, status}, 32'h92);
        rd_chk("R7 factory kept", 8'h81);

        // R10: reset disarms, clears errors, keeps contents
        wr(8'h00, 16'h00C0);
        do_reset(1'b0);
        chk("R10 errors cleared", {24'd0, status}, 32'h80);
        wr(8'h86, 16'h0000);
        chk("R10 disarmed status", {24'd0, status}, 32'h80);
        read_all("R10 contents kept");

        // Random mix against the model
        for (int k = 0; k < 150; k++) begin
            a = 8'h7E + 8'($urandom_range(0, 12));
            d = 16'($urandom) | 16'($urandom);
            prog("R3 random", a, d, 1'b0);
            rd_chk("R3 random readback", a);
            if ($urandom_range(0, 3) == 0) begin
                wr(8'h00, 16'h0050); exp_ep = 1'b0; exp_el = 1'b0;
                chk("R9 random clear", {24'd0, status}, 32'h80);
            end
        end

        // R8: lock the user segment, try to undo it
        wr(8'h00, 16'h0050); exp_ep = 1'b0; exp_el = 1'b0;
        prog("R8 lock", 8'h80, 16'hFFFD, 1'b0);
        prog("R8 locked write", 8'h86, 16'h0000, 1'b0);
        chk("R8 lock status", {24'd0, status}, 32'h92);
        wr(8'h00, 16'h0050); exp_ep = 1'b0; exp_el = 1'b0;
        prog("R8 relock attempt", 8'h80, 16'hFFFF, 1'b0);
        do_reset(1'b0);
        rd_chk("R8 lock word", 8'h80);
        chk("R8 lock bit", {31'd0, exp_w[0][1]}, 32'd0);
        prog("R8 after reset", 8'h88, 16'h0000, 1'b0);
        chk("R8 still locked", {24'd0, status}, 32'h92);
        read_all("R8 final");

        finish_run();
    end
endmodule